// File: doc/BRIEF.md
# Run-time Programmable Nibble Substitution Unit

This unit applies a 4-bit to 4-bit substitution to every nibble of a 32-bit word. The mapping is not held in storage inside the block. It arrives with each request as two 32-bit words that together form a 64-bit table of sixteen 4-bit entries. Software can therefore load any S-box, whether a cipher layer, a permutation or a constant map, without the hardware changing.

A request is a one-cycle `start` pulse that presents the destination word and both table words. On the next clock edge the substituted word is captured into the output register, and `done` goes high for one cycle. The result stays at that value until another `start` arrives. Each nibble of the destination serves as an index into the table, and the selected entry replaces that nibble. All nibbles share the same table and are looked up independently of one another.

Top module: `nibble_sbox`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `done` is 0 and `result` is all zeros.
- R2: The table word is `{tbl_hi, tbl_lo}`. Entry i is bits [4i+3:4i] of it, so entry 0 is `tbl_lo[3:0]`, entry 7 is `tbl_lo[31:28]`, entry 8 is `tbl_hi[3:0]` and entry 15 is `tbl_hi[31:28]`.
- R3: Nibble k of `result`, bits [4k+3:4k], equals the table entry indexed by nibble k of `dest_in` as sampled with `start`.
- R4: Every nibble is substituted through the same table, and each result nibble depends only on its own input nibble. A destination whose nibbles are all equal yields a result whose nibbles are all equal.
- R5: `done` is 1 in exactly the cycle after each cycle in which `start` is 1, and 0 otherwise.
- R6: While `start` is 0, `result` keeps its value, and changes on `dest_in`, `tbl_hi` and `tbl_lo` have no effect on it.
- R7: The identity table (entry i equals i, that is `tbl_hi`=0xFEDCBA98 and `tbl_lo`=0x76543210) returns `dest_in` unchanged.
- R8: When `start` is held high on consecutive cycles, each cycle's operands produce their own result in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe; captures operands on this edge |
| dest_in | input | DATA_W | Word whose nibbles are substituted |
| tbl_hi | input | 32 | Upper half of the table (entries 8 to 15) |
| tbl_lo | input | 32 | Lower half of the table (entries 0 to 7) |
| result | output | DATA_W | Registered substituted word |
| done | output | 1 | One-cycle flag marking a new result |

## Verification
Every result of this block lands exactly one clock edge after the `start` that requested it. `done` and `result` are both due in that cycle, and `done` is due to clear one cycle later. The bench drives operands at a falling edge, lets a single rising edge pass, and samples at the next falling edge. It then checks both outputs again a cycle later to confirm the clear and the hold. For the back-to-back case, it samples each result in the cycle directly after the strobe that produced it, while the next operands are already being captured.

// File: rtl/nibble_sbox.sv
module nibble_sbox #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] dest_in,
  input  logic [31:0]       tbl_hi,
  input  logic [31:0]       tbl_lo,
  output logic [DATA_W-1:0] result,
  output logic              done
);
  localparam int NIB_W   = 4;
  localparam int ENTRIES = 1 << NIB_W;
  localparam int LANES   = DATA_W / NIB_W;

  logic [ENTRIES*NIB_W-1:0] tbl;
  logic [NIB_W-1:0]         entry [ENTRIES];
  logic [DATA_W-1:0]        subst;

  assign tbl = {tbl_hi, tbl_lo};

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    assign entry[e] = tbl[e*NIB_W +: NIB_W];
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign subst[k*NIB_W +: NIB_W] = entry[dest_in[k*NIB_W +: NIB_W]];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result <= '0;
      done   <= 1'b0;
    end else begin
      done <= start;
      if (start) result <= subst;
    end
  end
endmodule

// File: rtl/nibble_sbox_chk.sv
module nibble_sbox_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [DATA_W-1:0] dest_in,
  input logic [31:0]       tbl_hi,
  input logic [31:0]       tbl_lo,
  input logic [DATA_W-1:0] result,
  input logic              done
);
  localparam int LANES = DATA_W / 4;

  a_r5_done_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);

  a_r5_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done);

  a_r6_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(result));

  a_r7_identity_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (start && tbl_hi == 32'hFEDCBA98 && tbl_lo == 32'h76543210)
      |=> result == $past(dest_in));

  a_r4_zero_index_broadcast: assert property (@(posedge clk) disable iff (!rst_n)
    (start && dest_in == '0) |=> result == {LANES{$past(tbl_lo[3:0])}});

  a_r2_top_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (start && dest_in == '1) |=> result == {LANES{$past(tbl_hi[31:28])}});
endmodule

bind nibble_sbox nibble_sbox_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .dest_in(dest_in),
  .tbl_hi(tbl_hi), .tbl_lo(tbl_lo), .result(result), .done(done)
);

// File: tb/nibble_sbox_test.sv
module nibble_sbox_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] dest_in = '0, tbl_hi = '0, tbl_lo = '0;
  logic [31:0] result;
  logic        done;
  int          n_chk = 0, n_fail = 0;
  bit          ended = 1'b0;

  always #5 clk = ~clk;

  nibble_sbox uut (.clk(clk), .rst_n(rst_n), .start(start), .dest_in(dest_in),
                   .tbl_hi(tbl_hi), .tbl_lo(tbl_lo), .result(result), .done(done));

  // {dest, tbl_hi, tbl_lo, expected}
  localparam logic [127:0] VEC [8] = '{
    {32'h12345678, 32'hFEDCBA98, 32'h76543210, 32'h12345678},
    {32'hDEADBEEF, 32'hFEDCBA98, 32'h76543210, 32'hDEADBEEF},
    {32'h0F1E2D3C, 32'h01234567, 32'h89ABCDEF, 32'hF0E1D2C3},
    {32'h13579BDF, 32'hAAAAAAAA, 32'hAAAAAAAA, 32'hAAAAAAAA},
    {32'h12345678, 32'h0FEDCBA9, 32'h87654321, 32'h23456789},
    {32'hFFFF0000, 32'h0FEDCBA9, 32'h87654321, 32'h00001111},
    {32'hF0F0F00F, 32'h50000000, 32'h00000000, 32'h50505005},
    {32'h000000F0, 32'h00000000, 32'h00000009, 32'h99999909}
  };

  function automatic logic [31:0] model(input logic [31:0] d, input logic [31:0] hi,
                                        input logic [31:0] lo);
    logic [63:0] t;
    logic [31:0] r;
    t = {hi, lo};
    for (int k = 0; k < 8; k++) r[4*k +: 4] = t[4*d[4*k +: 4] +: 4];
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic issue(input logic [31:0] d, input logic [31:0] hi, input logic [31:0] lo);
    dest_in = d; tbl_hi = hi; tbl_lo = lo; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    #2000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] held, d, h, l;
    repeat (3) @(negedge clk);
    check("R1 reset done", {31'd0, done}, 32'd0);
    check("R1 reset result", result, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release done", {31'd0, done}, 32'd0);
    check("R1 after release result", result, 32'd0);

    for (int i = 0; i < 8; i++) begin
      issue(VEC[i][127:96], VEC[i][95:64], VEC[i][63:32]);
      check("R5 done after start", {31'd0, done}, 32'd1);
      check((i < 2) ? "R7 identity" : "R3 vector result", result, VEC[i][31:0]);
      @(negedge clk);
      check("R5 done clears", {31'd0, done}, 32'd0);
      check("R6 result held", result, VEC[i][31:0]);
    end

    // R2 entry placement: one-hot entry values
    for (int e = 0; e < 16; e++) begin
      logic [63:0] t;
      t = 64'd0;
      t[4*e +: 4] = 4'hC;
      issue({8{e[3:0]}}, t[63:32], t[31:0]);
      check("R2 entry position", result, 32'hCCCCCCCC);
    end

    // R4 independence: equal nibbles broadcast, random tables
    for (int i = 0; i < 24; i++) begin
      d = $urandom; h = $urandom; l = $urandom;
      issue(d, h, l);
      check("R3 random table", result, model(d, h, l));
    end
    d = 32'h77777777; h = $urandom; l = 32'h5A000000;
    issue(d, h, l);
    check("R4 equal nibbles broadcast", result, 32'h55555555);

    // R6 idle operand changes ignored
    held = result;
    @(negedge clk);
    dest_in = 32'hFFFFFFFF; tbl_hi = 32'h12341234; tbl_lo = 32'h9ABC9ABC;
    repeat (3) @(negedge clk);
    check("R6 idle ignore result", result, held);
    check("R6 idle no done", {31'd0, done}, 32'd0);

    // R8 back-to-back starts
    dest_in = 32'h01234567; tbl_hi = 32'hFEDCBA98; tbl_lo = 32'h76543210; start = 1'b1;
    @(negedge clk);
    check("R8 first result", result, 32'h01234567);
    check("R8 first done", {31'd0, done}, 32'd1);
    dest_in = 32'h01234567; tbl_hi = 32'h01234567; tbl_lo = 32'h89ABCDEF;
    @(negedge clk);
    start = 1'b0;
    check("R8 second result", result, 32'hFEDCBA98);
    check("R8 second done", {31'd0, done}, 32'd1);
    @(negedge clk);
    check("R8 done clears", {31'd0, done}, 32'd0);
    check("R8 result held", result, 32'hFEDCBA98);

    finish_run();
  end
endmodule